// File: doc/BRIEF.md
# ECC Error Logging Registers

This block sits beside a memory ECC checker and records what that checker reports. Each report is one cycle long and carries a class (correctable single-bit or uncorrectable multi-bit), the failing address and the memory row. The block keeps one error address record and a status record per class. It also holds an enable mask, and through it can raise a one-cycle system-error pulse. Software reaches all of this through a small register bus with a 2-bit select. Writes take effect at the clock edge. Reads are combinational.

The address record keeps the failing address rounded down to a 4 KB page, plus one flag per class. Once a record is captured it stays locked, so the first error survives until software acknowledges it by writing 1 to the matching flag. A multi-bit error may replace a record that holds only a single-bit error, because the uncorrectable event matters more. The status record keeps its own flag and the first row number for each class. Each class in the status record locks on its own.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr_o` is low. Register selects are: 0 address record, 1 status, 2 enables, 3 unused.
- R2: A single-bit report that arrives while neither address flag is set does three things. It loads the report's address bits 31:12 into bits 31:12 of the address record and sets bit 0. Bits 11:2 read zero.
- R3: While address bit 0 is set and no multi-bit report arrives, further single-bit reports leave the address record unchanged.
- R4: A multi-bit report that arrives while address bit 1 is clear does two things. It sets bit 1 and overwrites the page, even if bit 0 is already set. While bit 1 is set, no report of either class changes the address record.
- R5: Writing select 0 with a 1 in bit 0 or bit 1 clears that flag. A 0 in a flag bit leaves it unchanged. The page field cannot be written.
- R6: Status bit 0 is the single-bit flag and bits 3:1 hold the row of the first single-bit report. Both stay locked until software writes 1 to status bit 0. Clearing the flag keeps the row field.
- R7: Status bit 4 is the multi-bit flag and bits 7:5 hold the row of the first multi-bit report. It locks and clears in the same way, through status bit 4.
- R8: Select 2 is read/write in bits 1:0. Bit 0 enables single-bit signalling and bit 1 enables multi-bit signalling. All other bits, and every bit of select 3, read zero.
- R9: `serr_o` goes high for exactly one cycle after a report that is newly captured in the address record, but only when that report's class is enabled. It stays low otherwise.
- R10: Suppose a write clears a flag in the same cycle as a report of that class arrives. The clear takes effect first, so the report is captured.
- R11: A report with both class inputs high counts as multi-bit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_sbe_i | input | 1 | Single-bit error report strobe |
| err_mbe_i | input | 1 | Multi-bit error report strobe |
| err_addr_i | input | 32 | Address of the reported error |
| err_row_i | input | 3 | Row of the reported error |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| serr_o | output | 1 | One-cycle system-error pulse |

## Verification
The bench exercises the following cases:
- A multi-bit report landing on a record that holds only a single-bit error. A design with the wrong priority would keep the stale page, or would drop the multi-bit flag.
- A single-bit report arriving while the multi-bit flag is set. A leaky lock would show this as a changed page.
- A clear and a report of the same class in the same cycle. A design that checks the flag before applying the clear loses the error and emits no pulse.
- Reports of a disabled class, simultaneous class inputs, and the width of the pulse. These expose a pulse that is stretched or ungated, and a report that is counted twice.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {
    SEL_EAP  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NUM_CLS = 2;
  localparam int CLS_SBE = 0;
  localparam int CLS_MBE = 1;
endpackage

// File: rtl/ecc_addr_log.sv
module ecc_addr_log #(
  parameter int PAGE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_sbe_i,
  input  logic              ev_mbe_i,
  input  logic [PAGE_W-1:0] ev_page_i,
  input  logic              clr_sbe_i,
  input  logic              clr_mbe_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              sbe_o,
  output logic              mbe_o,
  output logic              cap_sbe_o,
  output logic              cap_mbe_o
);
  logic [PAGE_W-1:0] page_q;
  logic sbe_q, mbe_q;
  logic sbe_held, mbe_held;

  // clear applies before the capture decision
  assign sbe_held  = sbe_q & ~clr_sbe_i;
  assign mbe_held  = mbe_q & ~clr_mbe_i;
  assign cap_mbe_o = ev_mbe_i & ~mbe_held;
  assign cap_sbe_o = ev_sbe_i & ~sbe_held & ~mbe_held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
    end else begin
      sbe_q <= sbe_held | cap_sbe_o;
      mbe_q <= mbe_held | cap_mbe_o;
      if (cap_sbe_o || cap_mbe_o) page_q <= ev_page_i;
    end
  end

  assign page_o = page_q;
  assign sbe_o  = sbe_q;
  assign mbe_o  = mbe_q;
endmodule

// File: rtl/ecc_class_log.sv
module ecc_class_log #(
  parameter int ROW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [ROW_W-1:0] row_o
);
  logic             flag_q;
  logic [ROW_W-1:0] row_q;
  logic             held, cap;

  assign held = flag_q & ~clr_i;
  assign cap  = ev_i & ~held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else begin
      flag_q <= held | cap;
      if (cap) row_q <= row_i;
    end
  end

  assign flag_o = flag_q;
  assign row_o  = row_q;
endmodule

// File: rtl/ecc_reg_if.sv
module ecc_reg_if
  import ecc_log_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int ROW_W    = 3,
  localparam int PAGE_W  = DATA_W - PAGE_LSB,
  localparam int FLD_W   = ROW_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            reg_wr_i,
  input  logic [1:0]                      reg_sel_i,
  input  logic [DATA_W-1:0]               reg_wdata_i,
  input  logic [PAGE_W-1:0]               eap_page_i,
  input  logic [NUM_CLS-1:0]              eap_flag_i,
  input  logic [NUM_CLS-1:0]              sts_flag_i,
  input  logic [NUM_CLS-1:0][ROW_W-1:0]   sts_row_i,
  output logic [NUM_CLS-1:0]              clr_eap_o,
  output logic [NUM_CLS-1:0]              clr_sts_o,
  output logic [NUM_CLS-1:0]              cmd_en_o,
  output logic [DATA_W-1:0]               reg_rdata_o
);
  reg_sel_e sel;
  logic [NUM_CLS-1:0] cmd_q;
  logic [NUM_CLS*FLD_W-1:0] sts_word;
  logic unused_wdata;

  assign sel = reg_sel_e'(reg_sel_i);
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_CLS*FLD_W];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_fld
    assign sts_word[c*FLD_W +: FLD_W] = {sts_row_i[c], sts_flag_i[c]};
    assign clr_eap_o[c] = reg_wr_i && (sel == SEL_EAP) && reg_wdata_i[c];
    assign clr_sts_o[c] = reg_wr_i && (sel == SEL_STS) && reg_wdata_i[c*FLD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else if (reg_wr_i && sel == SEL_CMD) cmd_q <= reg_wdata_i[NUM_CLS-1:0];
  end
  assign cmd_en_o = cmd_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_EAP: begin
        reg_rdata_o[DATA_W-1:PAGE_LSB] = eap_page_i;
        reg_rdata_o[NUM_CLS-1:0]       = eap_flag_i;
      end
      SEL_STS: reg_rdata_o[NUM_CLS*FLD_W-1:0] = sts_word;
      SEL_CMD: reg_rdata_o[NUM_CLS-1:0]       = cmd_q;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int ROW_W    = 3,
  localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_sbe_i,
  input  logic              err_mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [ROW_W-1:0]  err_row_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              serr_o
);
  logic [NUM_CLS-1:0] ev_vec, cap_vec, eap_flag, clr_eap, clr_sts, cmd_en, sts_flag;
  logic [NUM_CLS-1:0][ROW_W-1:0] sts_row;
  logic [PAGE_W-1:0] eap_page;
  logic serr_q;
  logic unused_addr;

  assign unused_addr = ^err_addr_i[PAGE_LSB-1:0];

  // multi-bit dominates a report flagged as both
  assign ev_vec[CLS_MBE] = err_mbe_i;
  assign ev_vec[CLS_SBE] = err_sbe_i & ~err_mbe_i;

  ecc_addr_log #(.PAGE_W(PAGE_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_sbe_i  (ev_vec[CLS_SBE]),
    .ev_mbe_i  (ev_vec[CLS_MBE]),
    .ev_page_i (err_addr_i[ADDR_W-1:PAGE_LSB]),
    .clr_sbe_i (clr_eap[CLS_SBE]),
    .clr_mbe_i (clr_eap[CLS_MBE]),
    .page_o    (eap_page),
    .sbe_o     (eap_flag[CLS_SBE]),
    .mbe_o     (eap_flag[CLS_MBE]),
    .cap_sbe_o (cap_vec[CLS_SBE]),
    .cap_mbe_o (cap_vec[CLS_MBE])
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    ecc_class_log #(.ROW_W(ROW_W)) u_cls (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev_vec[c]),
      .row_i  (err_row_i),
      .clr_i  (clr_sts[c]),
      .flag_o (sts_flag[c]),
      .row_o  (sts_row[c])
    );
  end

  ecc_reg_if #(.DATA_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .ROW_W(ROW_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .eap_page_i  (eap_page),
    .eap_flag_i  (eap_flag),
    .sts_flag_i  (sts_flag),
    .sts_row_i   (sts_row),
    .clr_eap_o   (clr_eap),
    .clr_sts_o   (clr_sts),
    .cmd_en_o    (cmd_en),
    .reg_rdata_o (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b0;
    else         serr_q <= |(cap_vec & cmd_en);
  end
  assign serr_o = serr_q;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_sbe_i,
  input logic              err_mbe_i,
  input logic              reg_wr_i,
  input logic [1:0]        reg_sel_i,
  input logic [ADDR_W-1:0] reg_wdata_i,
  input logic              serr_o,
  input logic              eap_sbe,
  input logic              eap_mbe,
  input logic [PAGE_W-1:0] eap_page,
  input logic [1:0]        cmd_en
);
  logic wr_clr_sbe, wr_clr_mbe;
  assign wr_clr_sbe = reg_wr_i && reg_sel_i == 2'd0 && reg_wdata_i[0];
  assign wr_clr_mbe = reg_wr_i && reg_sel_i == 2'd0 && reg_wdata_i[1];

  p_serr_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past(err_sbe_i || err_mbe_i));

  p_sbe_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eap_sbe && !wr_clr_sbe && !err_mbe_i) |=> (eap_sbe && $stable(eap_page)));

  p_mbe_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eap_mbe && !wr_clr_mbe) |=> (eap_mbe && $stable(eap_page)));

  p_sbe_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eap_sbe) |-> $past(err_sbe_i && !err_mbe_i));

  p_cmd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_sel_i == 2'd2) |=> $stable(cmd_en));
endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_sbe_i   (err_sbe_i),
  .err_mbe_i   (err_mbe_i),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .serr_o      (serr_o),
  .eap_sbe     (eap_flag[0]),
  .eap_mbe     (eap_flag[1]),
  .eap_page    (eap_page),
  .cmd_en      (cmd_en)
);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
  localparam logic [1:0] OP_EV = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sel;
    logic [31:0] data;
    logic [1:0]  cls;   // {mbe, sbe}
    logic [2:0]  row;
    logic [31:0] exp;
    logic        serr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h0,        1'b0, 4'd1},  // R1
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'h0,        1'b0, 4'd1},  // R1
    '{OP_RD, 2'd2, 32'h0,        2'd0, 3'd0, 32'h0,        1'b0, 4'd1},  // R1
    '{OP_WR, 2'd2, 32'hFFFFFFFF, 2'd0, 3'd0, 32'h0,        1'b0, 4'd8},  // R8
    '{OP_RD, 2'd2, 32'h0,        2'd0, 3'd0, 32'h3,        1'b0, 4'd8},  // R8
    '{OP_EV, 2'd0, 32'h12345678, 2'd1, 3'd2, 32'h0,        1'b1, 4'd9},  // R9
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h12345001, 1'b0, 4'd2},  // R2
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'h05,       1'b0, 4'd6},  // R6
    '{OP_EV, 2'd0, 32'hAAAAA000, 2'd1, 3'd5, 32'h0,        1'b0, 4'd3},  // R3
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h12345001, 1'b0, 4'd3},  // R3
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'h05,       1'b0, 4'd6},  // R6
    '{OP_EV, 2'd0, 32'h87654321, 2'd2, 3'd6, 32'h0,        1'b1, 4'd4},  // R4
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h87654003, 1'b0, 4'd4},  // R4
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'hD5,       1'b0, 4'd7},  // R7
    '{OP_EV, 2'd0, 32'h11111000, 2'd2, 3'd1, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h87654003, 1'b0, 4'd4},  // R4
    '{OP_WR, 2'd0, 32'hFFFFF001, 2'd0, 3'd0, 32'h0,        1'b0, 4'd5},  // R5
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h87654002, 1'b0, 4'd5},  // R5
    '{OP_EV, 2'd0, 32'h22222000, 2'd1, 3'd3, 32'h0,        1'b0, 4'd4},  // R4
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h87654002, 1'b0, 4'd4},  // R4
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'hD5,       1'b0, 4'd6},  // R6
    '{OP_WR, 2'd0, 32'h00000002, 2'd0, 3'd0, 32'h0,        1'b0, 4'd5},  // R5
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h87654000, 1'b0, 4'd5},  // R5
    '{OP_WR, 2'd1, 32'h00000011, 2'd0, 3'd0, 32'h0,        1'b0, 4'd6},  // R6
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'hC4,       1'b0, 4'd7},  // R7
    '{OP_WR, 2'd2, 32'h00000001, 2'd0, 3'd0, 32'h0,        1'b0, 4'd8},  // R8
    '{OP_EV, 2'd0, 32'h33333000, 2'd2, 3'd7, 32'h0,        1'b0, 4'd9},  // R9
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h33333002, 1'b0, 4'd9},  // R9
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'hF4,       1'b0, 4'd7},  // R7
    '{OP_WR, 2'd0, 32'h00000002, 2'd0, 3'd0, 32'h0,        1'b0, 4'd5},  // R5
    '{OP_WR, 2'd1, 32'h00000010, 2'd0, 3'd0, 32'h0,        1'b0, 4'd7},  // R7
    '{OP_EV, 2'd0, 32'h44444000, 2'd3, 3'd1, 32'h0,        1'b0, 4'd11}, // R11
    '{OP_RD, 2'd0, 32'h0,        2'd0, 3'd0, 32'h44444002, 1'b0, 4'd11}, // R11
    '{OP_RD, 2'd1, 32'h0,        2'd0, 3'd0, 32'h34,       1'b0, 4'd11}, // R11
    '{OP_RD, 2'd3, 32'h0,        2'd0, 3'd0, 32'h0,        1'b0, 4'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_sbe = 1'b0, err_mbe = 1'b0;
  logic [31:0] err_addr = '0;
  logic [2:0] err_row = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic serr;
  int n_chk = 0, n_fail = 0;
  logic prev_serr = 1'b0;

  always #10 clk = ~clk;

  ecc_err_log dut (
    .clk_i(clk), .rst_ni(rst_n),
    .err_sbe_i(err_sbe), .err_mbe_i(err_mbe),
    .err_addr_i(err_addr), .err_row_i(err_row),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .serr_o(serr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic drive_idle();
    @(posedge clk);
    #1;
    err_sbe = 1'b0; err_mbe = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    drive_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 serr", {31'b0, serr}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check($sformatf("R9 serr v%0d", i), {31'b0, serr}, {31'b0, prev_serr});
      case (VEC[i].op)
        OP_EV: begin
          err_sbe = VEC[i].cls[0]; err_mbe = VEC[i].cls[1];
          err_addr = VEC[i].data; err_row = VEC[i].row;
        end
        OP_WR: begin
          reg_wr = 1'b1; reg_sel = VEC[i].sel; reg_wdata = VEC[i].data;
        end
        default: begin
          reg_sel = VEC[i].sel;
          #1 check($sformatf("R%0d v%0d", VEC[i].req, i), reg_rdata, VEC[i].exp);
        end
      endcase
      prev_serr = (VEC[i].op == OP_EV) ? VEC[i].serr : 1'b0;
      drive_idle();
    end

    // R10: clear and same-class report in one cycle
    wr(2'd0, 32'h3);
    wr(2'd1, 32'h11);
    wr(2'd2, 32'h3);
    @(negedge clk);
    err_sbe = 1'b1; err_addr = 32'h55555000; err_row = 3'd0;
    drive_idle();
    rd_chk(2'd0, 32'h55555001, "R2");
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h1;
    err_sbe = 1'b1; err_addr = 32'h66666000; err_row = 3'd3;
    drive_idle();
    @(negedge clk);
    check("R10 serr", {31'b0, serr}, 32'h1);
    reg_sel = 2'd0;
    #1 check("R10 addr", reg_rdata, 32'h66666001);
    @(negedge clk);
    check("R9 width", {31'b0, serr}, 32'h0);
    rd_chk(2'd1, 32'h21, "R6 row lock");

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(2'd0, 32'h0, "R1 eap");
    rd_chk(2'd1, 32'h0, "R1 sts");
    rd_chk(2'd2, 32'h0, "R1 cmd");
    check("R1 serr", {31'b0, serr}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule